// File: doc/BRIEF.md
# Serial Peripheral Shift Controller with Single-Wire Data Mode

This block moves bytes over an SPI link, either as the clock-owning master or as a slave that follows an external clock and select line. Software-side access is a small byte-wide register port with four addresses: control, baud, data and status. Writing the data address as master starts a transfer. Writing it as an idle slave preloads the byte to be shifted out. Reading the data address returns the last received byte and clears the completion flag.

Each pad-level pin has its own output-enable, so the block can drive tri-state pads directly. The block has two data-pin modes. In the normal mode, one pin carries data out and the other carries data in. In the single-wire mode, all data uses one pin, and that pin depends on the role: a master uses its MOSI pin and a slave uses its MISO pin. In single-wire mode a direction bit turns that pin's driver on or off.

The master clock comes from the bus clock through a two-stage divider. The first stage is a prescaler and the second is a power-of-two rate divider. A wait-mode input freezes the engine when the control register asks for that.

Top module: `spi_shift_unit`

## Requirements
- R1: After reset, all four registers read 0, all three output-enables are low and `sck_o` is low. Register addresses are: 0 control, 1 baud, 2 data, 3 status. Control bits are: bit0 enable, bit1 master role, bit2 single-wire mode, bit3 drive direction, bit4 halt in wait. Control bits 7:5 read 0.
- R2: The baud register holds a prescale select in bits 6:4 and a rate select in bits 2:0. Bits 7 and 3 read 0 and ignore writes. The register can be written and read back at any time, including during a transfer.
- R3: As master, SCK is low when idle. During a transfer SCK toggles every (prescale select + 1) * 2^(rate select) bus cycles, counted from the cycle after the start write. A byte takes 16 such half periods, and the last half period ends with SCK low.
- R4: A transfer uses SPI mode 0 and moves 8 bits MSB first. The outgoing bit is set before each rising SCK edge and changes after each falling edge. The input is sampled on the rising edge. The received byte is readable at address 2 after the transfer.
- R5: Status bit 7 (done) sets when the eighth bit has shifted and clears on a read strobe at address 2. Status bit 6 (busy) is high while a transfer is in progress.
- R6: A baud register write during an active transfer does not change that transfer's SCK timing. The new setting applies from the next started byte.
- R7: When control bit 4 is 1 and `wait_i` is high, the shift engine and baud counters hold their state. When control bit 4 is 0, `wait_i` has no effect on the transfer timing.
- R8: In normal mode, a master drives MOSI and SCK and takes data from MISO. A slave leaves MOSI and SCK undriven, takes data from MOSI, and drives MISO only while `ss_ni` is low.
- R9: In single-wire master mode, all data uses the MOSI pin. Its enable equals the direction bit, received bits are sampled from `mosi_i`, and MISO is never driven.
- R10: In single-wire slave mode, all data uses the MISO pin. Its enable is the direction bit while `ss_ni` is low, received bits are sampled from `miso_i`, and MOSI is never driven.
- R11: In normal mode, the direction bit has no effect on any output-enable.
- R12: A slave with `ss_ni` low shifts out the byte loaded by its last idle data write, MSB first. It samples on rising `sck_i` edges and flags done after the eighth falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (side effect at address 2) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| wait_i | input | 1 | System wait mode active |
| sck_i | input | 1 | Serial clock from pad (slave) |
| sck_o | output | 1 | Serial clock to pad (master) |
| sck_oe_o | output | 1 | Serial clock driver enable |
| ss_ni | input | 1 | Slave select, active low |
| mosi_i | input | 1 | MOSI pad input |
| mosi_o | output | 1 | MOSI pad output |
| mosi_oe_o | output | 1 | MOSI driver enable |
| miso_i | input | 1 | MISO pad input |
| miso_o | output | 1 | MISO pad output |
| miso_oe_o | output | 1 | MISO driver enable |

## Verification
Master transfers are run with the fastest divider setting and with two slower ones. The bytes used are 0x00 and 0xFF in both directions, plus alternating patterns. This separates a wrong SCK period, a wrong bit order and a stuck data path. The bench drives the unused data input with the inverse of the real data, so sampling the wrong pin in normal or single-wire mode shows up as an inverted received byte. Other runs change the baud setting mid-transfer and pulse wait with the halt bit both set and clear. These runs compare SCK on every cycle against a behavioural cycle count, which tells a live divider update or a missing freeze apart from a correct one. Slave runs use both pin modes and a slow external clock to check the synchronised edge path.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int REG_W = 8;
  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_BAUD = 2'd1,
    ADDR_DATA = 2'd2,
    ADDR_STAT = 2'd3
  } reg_addr_e;

  // bit4..bit0
  typedef struct packed {
    logic halt_wait;
    logic drive_dir;
    logic one_wire;
    logic master;
    logic enable;
  } ctrl_t;

  typedef struct packed {
    logic [SEL_W-1:0] pre_sel;
    logic [SEL_W-1:0] rate_sel;
  } baud_t;
endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] pre_sel_i,
  input  logic [SEL_W-1:0] rate_sel_i,
  output logic             half_tick_o
);
  localparam int DIV_W = (1 << SEL_W) - 1;

  logic [SEL_W-1:0] pre_cnt;
  logic [DIV_W-1:0] div_cnt, div_lim;
  logic             pre_wrap, div_last;

  always_comb begin
    div_lim     = DIV_W'((32'd1 << rate_sel_i) - 32'd1);
    pre_wrap    = run_i & (pre_cnt == pre_sel_i);
    div_last    = (div_cnt == div_lim);
    half_tick_o = pre_wrap & div_last;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (clr_i) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else if (run_i) begin
      pre_cnt <= pre_wrap ? '0 : pre_cnt + 1'b1;
      if (pre_wrap) div_cnt <= div_last ? '0 : div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              master_i,
  input  logic              run_i,
  input  logic              start_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              tick_i,
  input  logic              sck_i,
  input  logic              ss_ni,
  input  logic              sin_i,
  output logic              sck_o,
  output logic              sout_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int CNT_W = $clog2(DATA_W);

  logic [SYNC_N-1:0] sck_sync, ss_sync;
  logic              sck_seen, sck_m, m_busy, samp;
  logic [DATA_W-1:0] sh;
  logic [CNT_W-1:0]  bit_cnt;
  logic              slave_sel, rise_ev, fall_ev, last_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_sync <= '0;
      ss_sync  <= '1;
      sck_seen <= 1'b0;
    end else begin
      sck_sync <= {sck_sync[SYNC_N-2:0], sck_i};
      ss_sync  <= {ss_sync[SYNC_N-2:0], ss_ni};
      if (run_i) sck_seen <= sck_sync[SYNC_N-1];
    end
  end

  always_comb begin
    slave_sel = enable_i & ~master_i & ~ss_sync[SYNC_N-1];
    last_bit  = (bit_cnt == CNT_W'(DATA_W - 1));
    if (master_i) begin
      rise_ev = m_busy & tick_i & ~sck_m;
      fall_ev = m_busy & tick_i & sck_m;
    end else begin
      rise_ev = run_i & slave_sel & sck_sync[SYNC_N-1] & ~sck_seen;
      fall_ev = run_i & slave_sel & ~sck_sync[SYNC_N-1] & sck_seen;
    end
    done_o = fall_ev & last_bit;
    busy_o = master_i ? m_busy : slave_sel;
    sout_o = sh[DATA_W-1];
    sck_o  = sck_m;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy  <= 1'b0;
      sck_m   <= 1'b0;
      samp    <= 1'b0;
      sh      <= '0;
      bit_cnt <= '0;
      rx_o    <= '0;
    end else if (!enable_i) begin
      m_busy  <= 1'b0;
      sck_m   <= 1'b0;
      bit_cnt <= '0;
    end else begin
      if (start_i) begin
        m_busy  <= 1'b1;
        sck_m   <= 1'b0;
        sh      <= tx_i;
        bit_cnt <= '0;
      end else if (load_i) begin
        sh <= tx_i;
      end
      if (rise_ev) begin
        samp <= sin_i;
        if (master_i) sck_m <= 1'b1;
      end
      if (fall_ev) begin
        sh      <= {sh[DATA_W-2:0], samp};
        bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
        if (master_i) sck_m <= 1'b0;
        if (last_bit) begin
          rx_o <= {sh[DATA_W-2:0], samp};
          if (master_i) m_busy <= 1'b0;
        end
      end
      if (!master_i && !slave_sel) bit_cnt <= '0;
    end
  end
endmodule

// File: rtl/spi_pin_steer.sv
module spi_pin_steer (
  input  logic enable_i,
  input  logic master_i,
  input  logic one_wire_i,
  input  logic drive_dir_i,
  input  logic ss_ni,
  input  logic sout_i,
  input  logic mosi_i,
  input  logic miso_i,
  output logic mosi_o,
  output logic mosi_oe_o,
  output logic miso_o,
  output logic miso_oe_o,
  output logic sin_o
);
  always_comb begin
    mosi_o    = sout_i;
    miso_o    = sout_i;
    mosi_oe_o = 1'b0;
    miso_oe_o = 1'b0;
    if (master_i) begin
      sin_o     = one_wire_i ? mosi_i : miso_i;
      mosi_oe_o = enable_i & (one_wire_i ? drive_dir_i : 1'b1);
    end else begin
      sin_o     = one_wire_i ? miso_i : mosi_i;
      miso_oe_o = enable_i & ~ss_ni & (one_wire_i ? drive_dir_i : 1'b1);
    end
  end
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit
  import spi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       wait_i,
  input  logic       sck_i,
  output logic       sck_o,
  output logic       sck_oe_o,
  input  logic       ss_ni,
  input  logic       mosi_i,
  output logic       mosi_o,
  output logic       mosi_oe_o,
  input  logic       miso_i,
  output logic       miso_o,
  output logic       miso_oe_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl_q;
  baud_t             baud_q, baud_act;
  logic              done_q, busy, done_pulse, run_en, tick, sout, sin;
  logic              wr_data, start, load;
  logic [DATA_W-1:0] rx;
  logic              unused_wdata;

  assign unused_wdata = ^{wdata_i[7], wdata_i[3]};

  always_comb begin
    run_en  = ~(wait_i & ctrl_q.halt_wait);
    wr_data = wr_i & (reg_addr_e'(addr_i) == ADDR_DATA);
    start   = wr_data & ctrl_q.enable & ctrl_q.master & ~busy;
    load    = wr_data & ~ctrl_q.master & ~busy;
    sck_oe_o = ctrl_q.enable & ctrl_q.master;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      baud_q   <= '0;
      baud_act <= '0;
      done_q   <= 1'b0;
    end else begin
      if (wr_i && reg_addr_e'(addr_i) == ADDR_CTRL) ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
      if (wr_i && reg_addr_e'(addr_i) == ADDR_BAUD) baud_q <= {wdata_i[6:4], wdata_i[2:0]};
      if (start) baud_act <= baud_q;  // divider settings fixed per byte
      if (done_pulse) done_q <= 1'b1;
      else if (rd_i && reg_addr_e'(addr_i) == ADDR_DATA) done_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr_e'(addr_i))
      ADDR_CTRL: rdata_o = REG_W'(ctrl_q);
      ADDR_BAUD: rdata_o = {1'b0, baud_q.pre_sel, 1'b0, baud_q.rate_sel};
      ADDR_DATA: rdata_o = REG_W'(rx);
      default:   rdata_o = {done_q, busy, 6'b0};
    endcase
  end

  spi_baud_gen #(.SEL_W(SEL_W)) i_baud (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (~busy),
    .run_i      (run_en),
    .pre_sel_i  (baud_act.pre_sel),
    .rate_sel_i (baud_act.rate_sel),
    .half_tick_o(tick)
  );

  spi_shift_core #(.DATA_W(DATA_W)) i_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enable_i(ctrl_q.enable),
    .master_i(ctrl_q.master),
    .run_i   (run_en),
    .start_i (start),
    .load_i  (load),
    .tx_i    (wdata_i[DATA_W-1:0]),
    .tick_i  (tick),
    .sck_i   (sck_i),
    .ss_ni   (ss_ni),
    .sin_i   (sin),
    .sck_o   (sck_o),
    .sout_o  (sout),
    .busy_o  (busy),
    .done_o  (done_pulse),
    .rx_o    (rx)
  );

  spi_pin_steer i_steer (
    .enable_i   (ctrl_q.enable),
    .master_i   (ctrl_q.master),
    .one_wire_i (ctrl_q.one_wire),
    .drive_dir_i(ctrl_q.drive_dir),
    .ss_ni      (ss_ni),
    .sout_i     (sout),
    .mosi_i     (mosi_i),
    .miso_i     (miso_i),
    .mosi_o     (mosi_o),
    .mosi_oe_o  (mosi_oe_o),
    .miso_o     (miso_o),
    .miso_oe_o  (miso_oe_o),
    .sin_o      (sin)
  );
endmodule

// File: rtl/spi_shift_unit_chk.sv
module spi_shift_unit_chk
  import spi_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] addr_i,
  input logic       rd_i,
  input logic       wait_i,
  input logic       sck_o,
  input logic       mosi_oe_o,
  input logic       miso_oe_o,
  input ctrl_t      ctrl_q,
  input baud_t      baud_act,
  input logic       busy,
  input logic       done_q,
  input logic       done_pulse
);
  a_r8_single_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mosi_oe_o && miso_oe_o));

  a_r9_dir_off_undriven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.one_wire && !ctrl_q.drive_dir) |-> (!mosi_oe_o && !miso_oe_o));

  a_r11_normal_master_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.enable && ctrl_q.master && !ctrl_q.one_wire) |-> mosi_oe_o);

  a_r3_idle_sck_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.master && !busy) |-> !sck_o);

  a_r5_read_clears_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_DATA && !done_pulse) |=> !done_q);

  a_r6_baud_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.master && busy && $past(busy)) |-> $stable(baud_act));

  a_r7_wait_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_i && ctrl_q.halt_wait && ctrl_q.enable && ctrl_q.master) |=> $stable(sck_o));
endmodule

bind spi_shift_unit spi_shift_unit_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .rd_i      (rd_i),
  .wait_i    (wait_i),
  .sck_o     (sck_o),
  .mosi_oe_o (mosi_oe_o),
  .miso_oe_o (miso_oe_o),
  .ctrl_q    (ctrl_q),
  .baud_act  (baud_act),
  .busy      (busy),
  .done_q    (done_q),
  .done_pulse(done_pulse)
);

// File: tb/test_spi_shift_unit.sv
module test_spi_shift_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       wait_i = 1'b0, sck_i = 1'b0, ss_ni = 1'b1;
  logic       mosi_i = 1'b0, miso_i = 1'b0;
  logic       sck_o, sck_oe_o, mosi_o, mosi_oe_o, miso_o, miso_oe_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  spi_shift_unit i_spi_shift_unit (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i, .rdata_o, .wait_i,
    .sck_i, .sck_o, .sck_oe_o, .ss_ni, .mosi_i, .mosi_o, .mosi_oe_o,
    .miso_i, .miso_o, .miso_oe_o
  );

  function automatic void chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endfunction

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i); addr_i = a; #1 d = rdata_o;
  endtask

  task automatic rd_data(output logic [7:0] d);
    @(negedge clk_i); addr_i = 2'd2; rd_i = 1'b1; #1 d = rdata_o;
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic pins(input string req, input bit m_oe, input bit s_oe, input bit c_oe);
    #1;
    chk({req, " mosi_oe"}, mosi_oe_o, m_oe);
    chk({req, " miso_oe"}, miso_oe_o, s_oe);
    chk({req, " sck_oe"}, sck_oe_o, c_oe);
  endtask

  // master-side drive of the far slave's data onto the correct pad, inverse on the other
  task automatic m_line(input bit sw, input bit b);
    if (sw) begin mosi_i = b; miso_i = ~b; end
    else    begin miso_i = b; mosi_i = ~b; end
  endtask

  task automatic run_master(input logic [7:0] tx, input logic [7:0] slv, input int h,
                            input bit sw, input int fs, input int fl, input bit halt,
                            input int mid_it, input logic [7:0] mid_baud);
    int n, k;
    bit prev;
    logic [7:0] got, d;
    @(negedge clk_i);
    m_line(sw, slv[7]);
    addr_i = 2'd2; wdata_i = tx; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
    n = 0; k = 0; prev = 1'b0; got = '0;
    for (int it = 0; n < 16*h && it < 20000; it++) begin
      wait_i = (it >= fs) && (it < fs + fl);
      if (it == mid_it) begin addr_i = 2'd1; wdata_i = mid_baud; wr_i = 1'b1; end
      else wr_i = 1'b0;
      @(posedge clk_i);
      if (!(wait_i && halt)) n++;
      @(negedge clk_i);
      wr_i = 1'b0;
      chk("R3/R6/R7 sck per cycle", sck_o, (n < 16*h) && ((n / h) % 2 == 1));
      if (sck_o && !prev) got = {got[6:0], mosi_o};
      if (!sck_o && prev) begin k++; if (k < 8) m_line(sw, slv[7-k]); end
      prev = sck_o;
    end
    wait_i = 1'b0;
    peek(2'd3, d);
    chk("R5 done set busy clear", d, 8'h80);
    chk("R4 bits sent MSB first", got, tx);
    rd_data(d);
    chk("R4 byte received", d, slv);
    peek(2'd3, d);
    chk("R5 done cleared by read", d, 8'h00);
  endtask

  task automatic s_line(input bit sw, input bit b);
    if (sw) begin miso_i = b; mosi_i = ~b; end
    else    begin mosi_i = b; miso_i = ~b; end
  endtask

  task automatic run_slave(input logic [7:0] tx, input logic [7:0] mst, input bit sw);
    logic [7:0] got, d;
    got = '0;
    wr_reg(2'd2, tx);
    @(negedge clk_i); ss_ni = 1'b0; s_line(sw, mst[7]);
    repeat (8) @(negedge clk_i);
    for (int i = 0; i < 8; i++) begin
      got = {got[6:0], miso_o};
      sck_i = 1'b1;
      repeat (8) @(negedge clk_i);
      sck_i = 1'b0;
      if (i < 7) s_line(sw, mst[6-i]);
      repeat (8) @(negedge clk_i);
    end
    ss_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    peek(2'd3, d);
    chk("R12 slave done", d, 8'h80);
    chk("R12 slave bits sent", got, tx);
    rd_data(d);
    chk("R12 slave byte received", d, mst);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk_i);
    chk("R1 sck idle", sck_o, 0);
    pins("R1", 0, 0, 0);
    rst_ni = 1'b1;
    for (int a = 0; a < 4; a++) begin
      peek(2'(a), d);
      chk("R1 reg reset", d, 0);
    end

    wr_reg(2'd1, 8'hFF); peek(2'd1, d); chk("R2 reserved bits", d, 8'h77);
    wr_reg(2'd0, 8'hFF); peek(2'd0, d); chk("R1 ctrl upper bits", d, 8'h1F);
    wr_reg(2'd1, 8'h00); peek(2'd1, d); chk("R2 baud clear", d, 8'h00);

    wr_reg(2'd0, 8'h03); pins("R8 master", 1, 0, 1);
    wr_reg(2'd0, 8'h0B); pins("R11 master dir", 1, 0, 1);
    wr_reg(2'd0, 8'h03);

    run_master(8'hA5, 8'h3C, 1, 0, -1, 0, 0, -1, 8'h00);
    wr_reg(2'd1, 8'h11);
    run_master(8'h00, 8'hFF, 4, 0, -1, 0, 0, -1, 8'h00);
    run_master(8'hFF, 8'h00, 4, 0, -1, 0, 0, -1, 8'h00);

    wr_reg(2'd1, 8'h72);
    run_master(8'h3C, 8'hC3, 32, 0, -1, 0, 0, 40, 8'h00);
    peek(2'd1, d); chk("R2 R6 baud written mid-transfer", d, 8'h00);
    run_master(8'h5A, 8'h96, 1, 0, -1, 0, 0, -1, 8'h00);

    wr_reg(2'd1, 8'h01);
    wr_reg(2'd0, 8'h13);
    run_master(8'h81, 8'h7E, 2, 0, 5, 7, 1, -1, 8'h00);
    wr_reg(2'd0, 8'h03);
    run_master(8'h42, 8'hBD, 2, 0, 5, 7, 0, -1, 8'h00);

    wr_reg(2'd0, 8'h0F); pins("R9 one-wire master dir=1", 1, 0, 1);
    run_master(8'hC6, 8'h2B, 2, 1, -1, 0, 0, -1, 8'h00);
    wr_reg(2'd0, 8'h07); pins("R9 one-wire master dir=0", 0, 0, 1);

    wr_reg(2'd0, 8'h01); pins("R8 slave unselected", 0, 0, 0);
    ss_ni = 1'b0; pins("R8 slave selected", 0, 1, 0);
    wr_reg(2'd0, 8'h09); pins("R11 slave dir", 0, 1, 0);
    ss_ni = 1'b1;
    wr_reg(2'd0, 8'h01);
    run_slave(8'hB4, 8'h69, 0);

    wr_reg(2'd0, 8'h0D);
    ss_ni = 1'b0; pins("R10 one-wire slave dir=1", 0, 1, 0);
    wr_reg(2'd0, 8'h05); pins("R10 one-wire slave dir=0", 0, 0, 0);
    ss_ni = 1'b1;
    wr_reg(2'd0, 8'h0D);
    repeat (4) @(negedge clk_i);
    run_slave(8'h1E, 8'hD2, 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule